// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a 20-bit physical address for a 16-bit processor datapath. It keeps the four segment registers (code, data, stack and extra) itself. For each request it picks the segment that the access type calls for and forms the 16-bit effective offset. It then returns the physical address and the identifier of the segment it used, one clock after the request.

The datapath supplies the current contents of the instruction pointer, the stack pointer, the two base registers and the two index registers as plain inputs. A request names an access kind, a base, an index and a displacement mode, and it can carry a segment override. The offset is first summed and wrapped to 16 bits. The segment is then shifted left by four bits and added, and that sum wraps within the 20-bit space. Segment registers are loaded through a simple write port.

Top module: `seg_agen`

## Requirements
- R1: A request with `req_valid` high yields `out_valid` high on the next cycle, with `phys_addr` = (segment × 16 + offset) mod 2^20.
- R2: For a data access (`acc_kind`=1), offset = base + index + displacement mod 2^16. Base codes: 0 none, 1 `bx`, 2 `bp`. Index codes: 0 none, 1 `si`, 2 `di`.
- R3: Displacement mode 0 adds nothing and ignores `disp`. Mode 1 sign-extends `disp[7:0]` and ignores `disp[15:8]`. Mode 2 adds all 16 bits of `disp`.
- R4: An instruction fetch (`acc_kind`=0) uses the code segment with `ip`, and the override is ignored.
- R5: A data access defaults to the data segment, or to the stack segment when its base code is 2 (`bp`).
- R6: A stack access (`acc_kind`=2) uses the stack segment with `sp`, and the override is ignored.
- R7: A string source (`acc_kind`=3) uses `si` with the data segment by default. A string destination (`acc_kind`=4) uses `di` with the extra segment, and the override is ignored.
- R8: When `ovr_valid` is high, `ovr_sel` replaces the default segment for data accesses and string sources. Segment codes are 0 extra, 1 code, 2 stack, 3 data, and `seg_used` reports the code that was used.
- R9: `seg_wr_en` loads `seg_wr_data` into the segment selected by `seg_wr_sel` (same codes). A request in the same cycle still sees the old value, and later requests see the new one.
- R10: Reset clears every segment register, `out_valid`, `phys_addr` and `seg_used`.
- R11: In a cycle without a request, `out_valid` goes low on the next cycle and `phys_addr` and `seg_used` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment to write |
| seg_wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request strobe |
| acc_kind | input | 3 | Access kind |
| base_sel | input | 2 | Base register choice |
| idx_sel | input | 2 | Index register choice |
| disp_mode | input | 2 | Displacement mode |
| disp | input | 16 | Displacement value |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| ip | input | 16 | Instruction pointer value |
| sp | input | 16 | Stack pointer value |
| bx | input | 16 | Base register value |
| bp | input | 16 | Frame base register value |
| si | input | 16 | Source index value |
| di | input | 16 | Destination index value |
| out_valid | output | 1 | Result valid |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Segment code actually applied |

## Verification
The bench builds the block with its default widths: 16-bit offsets and a 4-bit segment shift. With these widths the 64 KB offset wrap is reached by a frame base near 0xFFF0 plus a small displacement or index. The 1 MB wrap is reached by loading a segment of 0xFFFF. The same widths let a table of fixed register values cover every access kind, with and without overrides. Directed steps cover the write/request collision and idle cycles.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_e;

    typedef enum logic [2:0] {
        ACC_FETCH   = 3'd0,
        ACC_DATA    = 3'd1,
        ACC_STACK   = 3'd2,
        ACC_STR_SRC = 3'd3,
        ACC_STR_DST = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_BX   = 2'd1,
        BASE_BP   = 2'd2
    } base_sel_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_SI   = 2'd1,
        IDX_DI   = 2'd2
    } idx_sel_e;

    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_8    = 2'd1,
        DISP_16   = 2'd2
    } disp_mode_e;

    localparam int NUM_SEGS = 4;

endpackage

// File: rtl/seg_agen_segregs.sv
module seg_agen_segregs
    import seg_agen_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  seg_id_e          wr_sel,
    input  logic [OFS_W-1:0] wr_data,
    input  seg_id_e          rd_sel,
    output logic [OFS_W-1:0] rd_data
);

    logic [OFS_W-1:0] seg_q [NUM_SEGS];

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (wr_en && (wr_sel == seg_id_e'(g))) begin
                seg_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/seg_agen_offset.sv
module seg_agen_offset
    import seg_agen_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  acc_kind_e        kind,
    input  base_sel_e        base_sel,
    input  idx_sel_e         idx_sel,
    input  disp_mode_e       disp_mode,
    input  logic [OFS_W-1:0] disp,
    input  logic [OFS_W-1:0] ip,
    input  logic [OFS_W-1:0] sp,
    input  logic [OFS_W-1:0] bx,
    input  logic [OFS_W-1:0] bp,
    input  logic [OFS_W-1:0] si,
    input  logic [OFS_W-1:0] di,
    output logic [OFS_W-1:0] offset
);

    localparam int SHORT_W = 8;

    logic [OFS_W-1:0] base_term;
    logic [OFS_W-1:0] idx_term;
    logic [OFS_W-1:0] disp_term;
    logic [OFS_W-1:0] ea_sum;

    always_comb begin
        unique case (base_sel)
            BASE_BX: base_term = bx;
            BASE_BP: base_term = bp;
            default: base_term = '0;
        endcase
        unique case (idx_sel)
            IDX_SI:  idx_term = si;
            IDX_DI:  idx_term = di;
            default: idx_term = '0;
        endcase
        unique case (disp_mode)
            DISP_8:  disp_term = {{(OFS_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
            DISP_16: disp_term = disp;
            default: disp_term = '0;
        endcase
    end

    assign ea_sum = base_term + idx_term + disp_term;

    always_comb begin
        unique case (kind)
            ACC_FETCH:   offset = ip;
            ACC_STACK:   offset = sp;
            ACC_STR_SRC: offset = si;
            ACC_STR_DST: offset = di;
            default:     offset = ea_sum;
        endcase
    end

endmodule

// File: rtl/seg_agen_select.sv
module seg_agen_select
    import seg_agen_pkg::*;
(
    input  acc_kind_e kind,
    input  base_sel_e base_sel,
    input  logic      ovr_valid,
    input  seg_id_e   ovr_sel,
    output seg_id_e   seg_sel
);

    seg_id_e dflt_seg;
    logic    ovr_allowed;

    always_comb begin
        unique case (kind)
            ACC_FETCH: begin
                dflt_seg    = SEG_CS;
                ovr_allowed = 1'b0;
            end
            ACC_STACK: begin
                dflt_seg    = SEG_SS;
                ovr_allowed = 1'b0;
            end
            ACC_STR_SRC: begin
                dflt_seg    = SEG_DS;
                ovr_allowed = 1'b1;
            end
            ACC_STR_DST: begin
                dflt_seg    = SEG_ES;
                ovr_allowed = 1'b0;
            end
            default: begin
                dflt_seg    = (base_sel == BASE_BP) ? SEG_SS : SEG_DS;
                ovr_allowed = 1'b1;
            end
        endcase
    end

    assign seg_sel = (ovr_valid && ovr_allowed) ? ovr_sel : dflt_seg;

endmodule

// File: rtl/seg_agen.sv
module seg_agen
    import seg_agen_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       seg_wr_en,
    input  logic [1:0]                 seg_wr_sel,
    input  logic [OFS_W-1:0]           seg_wr_data,
    input  logic                       req_valid,
    input  logic [2:0]                 acc_kind,
    input  logic [1:0]                 base_sel,
    input  logic [1:0]                 idx_sel,
    input  logic [1:0]                 disp_mode,
    input  logic [OFS_W-1:0]           disp,
    input  logic                       ovr_valid,
    input  logic [1:0]                 ovr_sel,
    input  logic [OFS_W-1:0]           ip,
    input  logic [OFS_W-1:0]           sp,
    input  logic [OFS_W-1:0]           bx,
    input  logic [OFS_W-1:0]           bp,
    input  logic [OFS_W-1:0]           si,
    input  logic [OFS_W-1:0]           di,
    output logic                       out_valid,
    output logic [OFS_W+SEG_SHIFT-1:0] phys_addr,
    output logic [1:0]                 seg_used
);

    localparam int PA_W = OFS_W + SEG_SHIFT;

    seg_id_e          seg_sel;
    logic [OFS_W-1:0] seg_val;
    logic [OFS_W-1:0] offset;
    logic [PA_W-1:0]  pa_sum;

    seg_agen_segregs #(.OFS_W(OFS_W)) u_segregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_id_e'(seg_wr_sel)),
        .wr_data (seg_wr_data),
        .rd_sel  (seg_sel),
        .rd_data (seg_val)
    );

    seg_agen_offset #(.OFS_W(OFS_W)) u_offset (
        .kind      (acc_kind_e'(acc_kind)),
        .base_sel  (base_sel_e'(base_sel)),
        .idx_sel   (idx_sel_e'(idx_sel)),
        .disp_mode (disp_mode_e'(disp_mode)),
        .disp      (disp),
        .ip        (ip),
        .sp        (sp),
        .bx        (bx),
        .bp        (bp),
        .si        (si),
        .di        (di),
        .offset    (offset)
    );

    seg_agen_select u_select (
        .kind      (acc_kind_e'(acc_kind)),
        .base_sel  (base_sel_e'(base_sel)),
        .ovr_valid (ovr_valid),
        .ovr_sel   (seg_id_e'(ovr_sel)),
        .seg_sel   (seg_sel)
    );

    // segment shifted up, offset zero-extended; carry out of PA_W drops
    assign pa_sum = {seg_val, {SEG_SHIFT{1'b0}}} + PA_W'(offset);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            phys_addr <= '0;
            seg_used  <= 2'(SEG_ES);
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                phys_addr <= pa_sum;
                seg_used  <= seg_sel;
            end
        end
    end

endmodule

// File: rtl/seg_agen_chk.sv
module seg_agen_chk
    import seg_agen_pkg::*;
#(
    parameter int PA_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      acc_kind,
    input logic [1:0]      base_sel,
    input logic            ovr_valid,
    input logic [1:0]      ovr_sel,
    input logic            out_valid,
    input logic [PA_W-1:0] phys_addr,
    input logic [1:0]      seg_used
);

    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(phys_addr) && $stable(seg_used))); // R11

    AST_FETCH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 3'(ACC_FETCH)) |=> seg_used == 2'(SEG_CS)); // R4

    AST_BP_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 3'(ACC_DATA) && base_sel == 2'(BASE_BP) && !ovr_valid)
        |=> seg_used == 2'(SEG_SS)); // R5

    AST_STACK_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 3'(ACC_STACK)) |=> seg_used == 2'(SEG_SS)); // R6

    AST_DST_ES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_kind == 3'(ACC_STR_DST)) |=> seg_used == 2'(SEG_ES)); // R7

    AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_valid && (acc_kind == 3'(ACC_DATA) || acc_kind == 3'(ACC_STR_SRC)))
        |=> seg_used == $past(ovr_sel)); // R8

endmodule

bind seg_agen seg_agen_chk #(.PA_W(OFS_W + SEG_SHIFT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .acc_kind  (acc_kind),
    .base_sel  (base_sel),
    .ovr_valid (ovr_valid),
    .ovr_sel   (ovr_sel),
    .out_valid (out_valid),
    .phys_addr (phys_addr),
    .seg_used  (seg_used)
);

// File: tb/seg_agen_test.sv
module seg_agen_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 18;

    typedef struct packed {
        logic [2:0]  acc;
        logic [1:0]  base;
        logic [1:0]  idx;
        logic [1:0]  dmode;
        logic [15:0] disp;
        logic        ov;
        logic [1:0]  os;
        logic [19:0] pa;
        logic [1:0]  seg;
    } vec_t;

    // segments: ES=1000 CS=F000 SS=2000 DS=3000
    // ip=0100 sp=FFFE bx=0200 bp=FFF0 si=0010 di=0020
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 2'd0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 20'hF0100, 2'd1}, // R4 fetch
        '{3'd0, 2'd0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd3, 20'hF0100, 2'd1}, // R4 override ignored
        '{3'd1, 2'd1, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 20'h30200, 2'd3}, // R5 bx -> DS
        '{3'd1, 2'd1, 2'd1, 2'd0, 16'h0000, 1'b0, 2'd0, 20'h30210, 2'd3}, // R2 bx+si
        '{3'd1, 2'd1, 2'd2, 2'd1, 16'h0080, 1'b0, 2'd0, 20'h301A0, 2'd3}, // R3 negative d8
        '{3'd1, 2'd2, 2'd0, 2'd1, 16'h007F, 1'b0, 2'd0, 20'h2006F, 2'd2}, // R2 wrap, R5 bp -> SS
        '{3'd1, 2'd2, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd0, 20'h1FFF0, 2'd0}, // R8 override to ES
        '{3'd1, 2'd0, 2'd0, 2'd2, 16'h1234, 1'b0, 2'd0, 20'h31234, 2'd3}, // R3 d16 direct
        '{3'd1, 2'd1, 2'd0, 2'd1, 16'hAB05, 1'b0, 2'd0, 20'h30205, 2'd3}, // R3 d8 upper ignored
        '{3'd2, 2'd0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 20'h2FFFE, 2'd2}, // R6 stack
        '{3'd2, 2'd0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd3, 20'h2FFFE, 2'd2}, // R6 override ignored
        '{3'd3, 2'd0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 20'h30010, 2'd3}, // R7 string source
        '{3'd3, 2'd0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd0, 20'h10010, 2'd0}, // R8 source override
        '{3'd4, 2'd0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 20'h10020, 2'd0}, // R7 string dest
        '{3'd4, 2'd0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd1, 20'h10020, 2'd0}, // R7 dest override ignored
        '{3'd1, 2'd1, 2'd0, 2'd0, 16'hFFFF, 1'b0, 2'd0, 20'h30200, 2'd3}, // R3 mode 0 ignores disp
        '{3'd1, 2'd1, 2'd1, 2'd0, 16'h0000, 1'b1, 2'd2, 20'h20210, 2'd2}, // R8 override to SS
        '{3'd1, 2'd2, 2'd1, 2'd0, 16'h0000, 1'b0, 2'd0, 20'h20000, 2'd2}  // R2 bp+si wraps to 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  acc_kind = '0;
    logic [1:0]  base_sel = '0;
    logic [1:0]  idx_sel = '0;
    logic [1:0]  disp_mode = '0;
    logic [15:0] disp = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] ip = 16'h0100;
    logic [15:0] sp = 16'hFFFE;
    logic [15:0] bx = 16'h0200;
    logic [15:0] bp = 16'hFFF0;
    logic [15:0] si = 16'h0010;
    logic [15:0] di = 16'h0020;
    logic        out_valid;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_agen uut (
        .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
        .seg_wr_data(seg_wr_data), .req_valid(req_valid), .acc_kind(acc_kind),
        .base_sel(base_sel), .idx_sel(idx_sel), .disp_mode(disp_mode), .disp(disp),
        .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .ip(ip), .sp(sp), .bx(bx), .bp(bp),
        .si(si), .di(di), .out_valid(out_valid), .phys_addr(phys_addr), .seg_used(seg_used)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_seg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en   = 1'b1;
        seg_wr_sel  = sel;
        seg_wr_data = val;
        @(negedge clk);
        seg_wr_en   = 1'b0;
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1;
        acc_kind  = v.acc;
        base_sel  = v.base;
        idx_sel   = v.idx;
        disp_mode = v.dmode;
        disp      = v.disp;
        ovr_valid = v.ov;
        ovr_sel   = v.os;
        @(negedge clk);
        req_valid = 1'b0;
        ovr_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "out_valid", 32'(out_valid), 32'd0);
        check("R10", "phys_addr", 32'(phys_addr), 32'd0);
        check("R10", "seg_used", 32'(seg_used), 32'd0);
        rst_n = 1'b1;

        // R10 segments cleared: data request before any write gives bare offset
        issue('{3'd1, 2'd1, 2'd0, 2'd0, 16'h0, 1'b0, 2'd0, 20'h0, 2'd0});
        check("R10", "phys after reset", 32'(phys_addr), 32'h00200);

        // R9 write DS in the same cycle as a request: old value used
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_data = 16'h3000;
        req_valid = 1'b1; acc_kind = 3'd1; base_sel = 2'd1; idx_sel = 2'd0;
        disp_mode = 2'd0; ovr_valid = 1'b0;
        @(negedge clk);
        seg_wr_en = 1'b0; req_valid = 1'b0;
        check("R9", "same-cycle write", 32'(phys_addr), 32'h00200);
        issue('{3'd1, 2'd1, 2'd0, 2'd0, 16'h0, 1'b0, 2'd0, 20'h0, 2'd0});
        check("R9", "after write", 32'(phys_addr), 32'h30200);

        write_seg(2'd0, 16'h1000);
        write_seg(2'd1, 16'hF000);
        write_seg(2'd2, 16'h2000);

        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i]);
            check("R1", $sformatf("vec %0d out_valid", i), 32'(out_valid), 32'd1);
            check("R1", $sformatf("vec %0d phys_addr", i), 32'(phys_addr), 32'(VECS[i].pa));
            check("R8", $sformatf("vec %0d seg_used", i), 32'(seg_used), 32'(VECS[i].seg));
        end

        // R11 idle cycle: valid drops, outputs hold last result
        @(negedge clk);
        check("R11", "out_valid idle", 32'(out_valid), 32'd0);
        check("R11", "phys hold", 32'(phys_addr), 32'h20000);
        check("R11", "seg hold", 32'(seg_used), 32'd2);

        // R1 20-bit wrap: CS=FFFF, ip=0020
        write_seg(2'd1, 16'hFFFF);
        ip = 16'h0020;
        issue('{3'd0, 2'd0, 2'd0, 2'd0, 16'h0, 1'b0, 2'd0, 20'h0, 2'd0});
        check("R1", "20-bit wrap", 32'(phys_addr), 32'h00010);
        check("R4", "wrap seg", 32'(seg_used), 32'd1);

        @(negedge clk);
        finish_run();
    end

endmodule